// File: doc/BRIEF.md
# Receive Sample Packer with Alternate-Sample Filter

This block sits between a parallel receive port and a 32-bit word FIFO that a DMA engine drains. Each incoming sample is 8, 16 or 24 bits wide. A configurable filter can discard every other sample, keeping only the even-indexed or only the odd-indexed ones. Each kept sample is then either widened to a full 32-bit word, by sign extension or zero fill, or placed into one lane of a 32-bit word that is being built up. The lanes fill from the least significant end or from the most significant end, as configured.

Completed words go into a small output FIFO. The FIFO presents a valid/ready word stream and raises a watermark flag when its fill level reaches a set threshold, so that the DMA engine can be serviced urgently. An end-of-frame marker on the input flushes a partly filled word. The input side has a ready signal, so no sample is lost while the output side is stalled. Configuration is expected to stay stable within a frame.

Top module: `rx_sample_packer`

## Requirements
- R1: `cfgWidth` selects the sample width: 0 = 8 bits, 1 = 16 bits, 2 or 3 = 24 bits. Only the low bits of `inData` are used, and any bits above the selected width are ignored.
- R2: When packing is off (`cfgPack`=0), each kept sample is emitted as one 32-bit word. The upper bits are zero when `cfgSignExt`=0 and copies of the sample's top bit when `cfgSignExt`=1.
- R3: 24-bit samples are never packed. With `cfgPack`=1 each one is still emitted alone, extended as in R2.
- R4: With packing on and 8-bit samples, four kept samples form one word. With `cfgBigEnd`=0 the first sample lands in bits 7:0 and the following ones in successively higher bytes. With `cfgBigEnd`=1 the first sample lands in bits 31:24 and the following ones in successively lower bytes.
- R5: With packing on and 16-bit samples, two kept samples form one word. With `cfgBigEnd`=0 the first sample lands in bits 15:0, and with `cfgBigEnd`=1 it lands in bits 31:16.
- R6: `cfgKeep` controls the filter: 0 or 3 keeps every sample, 1 keeps indices 0, 2, 4 and so on, and 2 keeps indices 1, 3, 5 and so on. The index counts accepted samples from the start of a frame, and the first sample of a frame has index 0.
- R7: An accepted sample with `inLast`=1 ends the frame. A partly filled word is emitted at that point with its unused lanes zero, and this happens even when the last sample itself is dropped by the filter. The next accepted sample has index 0.
- R8: `inReady` is low whenever the output FIFO is full. Every word is delivered exactly once, in order, under any pattern of `outReady`.
- R9: `watermark` is high exactly when the FIFO holds at least `WM_LEVEL` words.
- R10: After reset, `outValid`=0, `watermark`=0 and `inReady`=1.
- R11: While `outValid`=1 and `outReady`=0, `outValid` stays high and `outData` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWidth | input | 2 | Sample width select |
| cfgPack | input | 1 | Pack samples into 32-bit words |
| cfgBigEnd | input | 1 | First sample fills the most significant lane |
| cfgSignExt | input | 1 | Sign-extend instead of zero fill |
| cfgKeep | input | 2 | Alternate-sample filter select |
| inValid | input | 1 | Input sample present |
| inReady | output | 1 | Input sample accepted this cycle if valid |
| inData | input | 24 | Input sample, right-aligned |
| inLast | input | 1 | Sample is the last of its frame |
| outValid | output | 1 | Output word available |
| outReady | input | 1 | Consumer takes the output word |
| outData | output | 32 | Output word |
| watermark | output | 1 | FIFO level at or above threshold |

## Verification
Two functions can fall in the same cycle: a word completing in the packer, which pushes into the FIFO, and the consumer popping the head word. The FIFO level must then stay constant, and neither word may be lost or duplicated. The bench provokes this by throttling `outReady` at random during a sweep over all 72 combinations of width, packing, order, extension and filter. Each frame length is chosen so that a partial flush occurs and, for some filters, the final sample is dropped. Every popped word is compared in order against a word list that the bench computes arithmetically, and the list must be fully drained afterwards.

// File: rtl/rxpk_pkg.sv
package rxpk_pkg;
  // Width select codes
  localparam logic [1:0] SEL_W8  = 2'd0;
  localparam logic [1:0] SEL_W16 = 2'd1;
  // Filter select codes
  localparam logic [1:0] KEEP_EVEN = 2'd1;
  localparam logic [1:0] KEEP_ODD  = 2'd2;

  // Strobes from control to datapath
  typedef struct packed {
    logic       load;   // insert current sample into lane
    logic       first;  // lane 0 of a new word
    logic       push;   // word complete, write to FIFO
    logic [1:0] lane;   // lane index in fill order
  } laneStrobe_t;
endpackage

// File: rtl/rxpk_ctrl.sv
module rxpk_ctrl
  import rxpk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  cfgWidth,
  input  logic        cfgPack,
  input  logic [1:0]  cfgKeep,
  input  logic        inValid,
  input  logic        inLast,
  input  logic        fifoFull,
  output logic        inReady,
  output laneStrobe_t stb
);
  logic [1:0] laneCnt;
  logic [1:0] lastLane;
  logic       oddPos;
  logic       keepNow;
  logic       accept;

  always_comb begin
    lastLane = 2'd0;
    if (cfgPack) begin
      case (cfgWidth)
        SEL_W8:  lastLane = 2'd3;
        SEL_W16: lastLane = 2'd1;
        default: lastLane = 2'd0;
      endcase
    end
    case (cfgKeep)
      KEEP_EVEN: keepNow = !oddPos;
      KEEP_ODD:  keepNow = oddPos;
      default:   keepNow = 1'b1;
    endcase
  end

  assign inReady = !fifoFull;
  assign accept  = inValid && inReady;

  always_comb begin
    stb.load  = accept && keepNow;
    stb.first = (laneCnt == 2'd0);
    stb.lane  = laneCnt;
    stb.push  = accept && ((keepNow && ((laneCnt == lastLane) || inLast)) ||
                           (!keepNow && inLast && (laneCnt != 2'd0)));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      laneCnt <= 2'd0;
      oddPos  <= 1'b0;
    end else begin
      if (stb.push)      laneCnt <= 2'd0;
      else if (stb.load) laneCnt <= laneCnt + 2'd1;
      if (accept)        oddPos  <= inLast ? 1'b0 : !oddPos;
    end
  end
endmodule

// File: rtl/rxpk_datapath.sv
module rxpk_datapath
  import rxpk_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int WORD_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          cfgWidth,
  input  logic                cfgPack,
  input  logic                cfgBigEnd,
  input  logic                cfgSignExt,
  input  logic [SAMPLE_W-1:0] inData,
  input  laneStrobe_t         stb,
  output logic [WORD_W-1:0]   wordOut
);
  localparam int NARROW_W = 8;
  localparam int MID_W    = 16;

  logic [WORD_W-1:0] accum;
  logic [WORD_W-1:0] extended;
  logic [WORD_W-1:0] laneVal;
  logic [WORD_W-1:0] assembled;
  logic [1:0]        pos;
  logic [4:0]        shift;
  logic              packActive;

  always_comb begin
    case (cfgWidth)
      SEL_W8:  extended = {{(WORD_W-NARROW_W){cfgSignExt & inData[NARROW_W-1]}}, inData[NARROW_W-1:0]};
      SEL_W16: extended = {{(WORD_W-MID_W){cfgSignExt & inData[MID_W-1]}}, inData[MID_W-1:0]};
      default: extended = {{(WORD_W-SAMPLE_W){cfgSignExt & inData[SAMPLE_W-1]}}, inData};
    endcase
    packActive = cfgPack && (cfgWidth == SEL_W8 || cfgWidth == SEL_W16);
    pos   = 2'd0;
    shift = 5'd0;
    laneVal = extended;
    if (packActive) begin
      if (cfgWidth == SEL_W8) begin
        pos     = cfgBigEnd ? (2'd3 - stb.lane) : stb.lane;
        shift   = {pos, 3'b000};
        laneVal = {{(WORD_W-NARROW_W){1'b0}}, inData[NARROW_W-1:0]};
      end else begin
        pos     = {1'b0, cfgBigEnd ? !stb.lane[0] : stb.lane[0]};
        shift   = {pos[0], 4'b0000};
        laneVal = {{(WORD_W-MID_W){1'b0}}, inData[MID_W-1:0]};
      end
    end
    assembled = (stb.first ? '0 : accum) | (laneVal << shift);
    wordOut   = stb.load ? assembled : accum;
  end

  always_ff @(posedge clk) begin
    if (!rstN)         accum <= '0;
    else if (stb.push) accum <= '0;
    else if (stb.load) accum <= assembled;
  end
endmodule

// File: rtl/rxpk_fifo.sv
module rxpk_fifo #(
  parameter int W        = 32,
  parameter int DEPTH    = 4,
  parameter int WM_LEVEL = 3,
  parameter int LVL_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [W-1:0]     pushData,
  input  logic             pop,
  output logic [W-1:0]     popData,
  output logic             notEmpty,
  output logic             full,
  output logic             watermark,
  output logic [LVL_W-1:0] level
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic             doPop;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign notEmpty  = (level != '0);
  assign full      = (level == LVL_W'(DEPTH));
  assign watermark = (level >= LVL_W'(WM_LEVEL));
  assign popData   = mem[rdPtr];
  assign doPop     = pop && notEmpty;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (push) begin
        mem[wrPtr] <= pushData;
        wrPtr      <= nextPtr(wrPtr);
      end
      if (doPop) rdPtr <= nextPtr(rdPtr);
      case ({push, doPop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/rx_sample_packer.sv
module rx_sample_packer
  import rxpk_pkg::*;
#(
  parameter int SAMPLE_W   = 24,
  parameter int WORD_W     = 32,
  parameter int FIFO_DEPTH = 4,
  parameter int WM_LEVEL   = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          cfgWidth,
  input  logic                cfgPack,
  input  logic                cfgBigEnd,
  input  logic                cfgSignExt,
  input  logic [1:0]          cfgKeep,
  input  logic                inValid,
  output logic                inReady,
  input  logic [SAMPLE_W-1:0] inData,
  input  logic                inLast,
  output logic                outValid,
  input  logic                outReady,
  output logic [WORD_W-1:0]   outData,
  output logic                watermark
);
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

  laneStrobe_t       stb;
  logic              fifoFull;
  logic              pushWord;
  logic [WORD_W-1:0] pushData;
  logic [LVL_W-1:0]  fifoLevel;

  assign pushWord = stb.push;

  rxpk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWidth(cfgWidth), .cfgPack(cfgPack),
    .cfgKeep(cfgKeep), .inValid(inValid), .inLast(inLast),
    .fifoFull(fifoFull), .inReady(inReady), .stb(stb)
  );

  rxpk_datapath #(.SAMPLE_W(SAMPLE_W), .WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .cfgWidth(cfgWidth), .cfgPack(cfgPack),
    .cfgBigEnd(cfgBigEnd), .cfgSignExt(cfgSignExt), .inData(inData),
    .stb(stb), .wordOut(pushData)
  );

  rxpk_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH), .WM_LEVEL(WM_LEVEL), .LVL_W(LVL_W)) u_fifo (
    .clk(clk), .rstN(rstN), .push(pushWord), .pushData(pushData),
    .pop(outReady), .popData(outData), .notEmpty(outValid),
    .full(fifoFull), .watermark(watermark), .level(fifoLevel)
  );
endmodule

// File: rtl/rx_sample_packer_chk.sv
module rx_sample_packer_chk #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 4,
  parameter int LVL_W  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              inReady,
  input logic              outValid,
  input logic              outReady,
  input logic [WORD_W-1:0] outData,
  input logic              watermark,
  input logic              pushWord,
  input logic [WORD_W-1:0] pushData,
  input logic [LVL_W-1:0]  fifoLevel,
  input logic              cfgPack,
  input logic [1:0]        cfgWidth,
  input logic              cfgSignExt
);
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (fifoLevel == LVL_W'(DEPTH)) |-> !inReady); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    fifoLevel <= LVL_W'(DEPTH)); // R8
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData))); // R11
  AST_WM_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(watermark) |-> $past(pushWord)); // R9
  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rstN)
    (pushWord && !cfgPack && cfgWidth == 2'd0 && !cfgSignExt) |-> (pushData[WORD_W-1:8] == '0)); // R2
endmodule

bind rx_sample_packer rx_sample_packer_chk #(.WORD_W(WORD_W), .DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rstN(rstN), .inReady(inReady), .outValid(outValid), .outReady(outReady),
  .outData(outData), .watermark(watermark), .pushWord(pushWord), .pushData(pushData),
  .fifoLevel(fifoLevel), .cfgPack(cfgPack), .cfgWidth(cfgWidth), .cfgSignExt(cfgSignExt)
);

// File: tb/rx_sample_packer_tb.sv
module rx_sample_packer_tb;
  localparam int DEPTH = 4;
  localparam int WM    = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  cfgWidth = '0;
  logic        cfgPack = 1'b0, cfgBigEnd = 1'b0, cfgSignExt = 1'b0;
  logic [1:0]  cfgKeep = '0;
  logic        inValid = 1'b0, inLast = 1'b0, outReady = 1'b0;
  logic [23:0] inData = '0;
  logic        inReady, outValid, watermark;
  logic [31:0] outData;

  int nChecks = 0, nFails = 0;
  bit randReady = 1'b0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #2 clk = ~clk;

  rx_sample_packer #(.FIFO_DEPTH(DEPTH), .WM_LEVEL(WM)) u_dut (
    .clk(clk), .rstN(rstN), .cfgWidth(cfgWidth), .cfgPack(cfgPack),
    .cfgBigEnd(cfgBigEnd), .cfgSignExt(cfgSignExt), .cfgKeep(cfgKeep),
    .inValid(inValid), .inReady(inReady), .inData(inData), .inLast(inLast),
    .outValid(outValid), .outReady(outReady), .outData(outData), .watermark(watermark)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s w=%0d pk=%0d be=%0d sx=%0d kp=%0d got %h exp %h",
               tag, cfgWidth, cfgPack, cfgBigEnd, cfgSignExt, cfgKeep, got, exp);
    end
  endtask

  // Consumer: decides ready at each falling edge and checks the word the next edge pops
  always @(negedge clk) begin
    if (rstN) begin
      outReady = randReady ? (($urandom % 4) != 0) : 1'b0;
      if (outValid && outReady) begin
        if (expQ.size() == 0) check(1'b0, "R8 extra word", outData, 32'h0);
        else begin
          logic [31:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(outData == e, t, outData, e);
        end
      end
    end
  end

  // Called at a falling edge; returns at the falling edge after acceptance
  task automatic sendSample(input logic [23:0] d, input bit last);
    inValid = 1'b1; inData = d; inLast = last;
    while (!inReady) @(negedge clk);
    @(negedge clk);
    inValid = 1'b0; inLast = 1'b0;
  endtask

  function automatic logic [31:0] extendRef(input logic [23:0] d, input int w, input bit sx);
    logic [31:0] m, v;
    m = (32'h1 << w) - 32'h1;
    v = {8'h0, d} & m;
    if (sx && v[w-1]) v = v | ~m;
    return v;
  endfunction

  task automatic runFrame(input int n);
    logic [23:0] smp[$];
    int  wbits, per, k, pos;
    logic [31:0] acc;
    string tag;
    bit keep;
    wbits = (cfgWidth == 2'd0) ? 8 : (cfgWidth == 2'd1) ? 16 : 24;
    per   = (cfgPack && cfgWidth < 2) ? ((cfgWidth == 2'd0) ? 4 : 2) : 1;
    // R1 upper bits ignored, R6 filter and R7 flush apply to every tag
    tag   = (per == 1) ? (cfgPack ? "R3/R1/R6/R7" : "R2/R1/R6/R7")
                       : ((per == 4) ? "R4/R1/R6/R7" : "R5/R1/R6/R7");
    acc = '0; k = 0;
    for (int i = 0; i < n; i++) begin
      logic [23:0] d;
      d = 24'($urandom);
      smp.push_back(d);
      keep = (cfgKeep == 2'd1) ? (i % 2 == 0) : (cfgKeep == 2'd2) ? (i % 2 == 1) : 1'b1;
      if (keep) begin
        if (per == 1) begin
          expQ.push_back(extendRef(d, wbits, cfgSignExt)); tagQ.push_back(tag);
        end else begin
          pos = cfgBigEnd ? (per - 1 - k) : k;
          acc = acc | ((({8'h0, d}) & ((32'h1 << wbits) - 32'h1)) << (pos * wbits));
          k++;
          if (k == per) begin
            expQ.push_back(acc); tagQ.push_back(tag); acc = '0; k = 0;
          end
        end
      end
    end
    if (k != 0) begin expQ.push_back(acc); tagQ.push_back(tag); end
    for (int i = 0; i < n; i++) sendSample(smp[i], i == n - 1);
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(outValid == 1'b0, "R10 outValid", {31'b0, outValid}, 32'h0);
    check(watermark == 1'b0, "R10 watermark", {31'b0, watermark}, 32'h0);
    check(inReady == 1'b1, "R10 inReady", {31'b0, inReady}, 32'h1);

    // R9 / R8 / R11: fill the FIFO with the consumer stalled
    cfgWidth = 2'd1; cfgPack = 1'b0; cfgKeep = 2'd0; cfgSignExt = 1'b1;
    for (int k = 1; k <= DEPTH; k++) begin
      logic [23:0] d;
      d = 24'(k * 24'h1357 + 24'h8000);
      expQ.push_back(extendRef(d, 16, 1'b1)); tagQ.push_back("R2/R8");
      sendSample(d, 1'b0);
      check(watermark == (k >= WM), "R9 watermark level", {31'b0, watermark}, {31'b0, k >= WM});
      check(outValid == 1'b1, "R11 outValid", {31'b0, outValid}, 32'h1);
    end
    begin
      logic [23:0] d;
      d = 24'h00_00F1;
      expQ.push_back(extendRef(d, 16, 1'b1)); tagQ.push_back("R8 held sample");
      fork
        sendSample(d, 1'b1);
        begin
          repeat (3) @(negedge clk);
          check(inReady == 1'b0, "R8 full stall", {31'b0, inReady}, 32'h0);
          check(outData == expQ[0], "R11 hold data", outData, expQ[0]);
          randReady = 1'b1;
        end
      join
    end
    drain();

    // Sweep every configuration with random throttling
    for (int w = 0; w < 3; w++)
      for (int pk = 0; pk < 2; pk++)
        for (int be = 0; be < 2; be++)
          for (int sx = 0; sx < 2; sx++)
            for (int kp = 0; kp < 3; kp++) begin
              cfgWidth = 2'(w); cfgPack = pk[0]; cfgBigEnd = be[0];
              cfgSignExt = sx[0]; cfgKeep = 2'(kp);
              runFrame(5);
              runFrame(6);
              runFrame(9);
              drain();
            end
    // R8: nothing left over
    check(outValid == 1'b0, "R8 no extra words", {31'b0, outValid}, 32'h0);
    check(expQ.size() == 0, "R8 all words seen", 32'(expQ.size()), 32'h0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired, %0d words outstanding", expQ.size());
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule